// File: doc/BRIEF.md
# Memory Barrier Ordering Gate

This block sits between an access scheduler and the memory system and enforces ordering around barrier operations. It counts the reads and the writes that have issued but not yet completed. When a barrier arrives, its type code decides two things: which outstanding classes must drain before the barrier can retire, and which classes of later accesses are held back until it does.

Six barrier types are decoded, and every other code falls back to the full completion barrier. Together they give a full fence, fences on writes only or on reads only, a one-sided acquire that drains reads and holds back everything, and a one-sided release that drains everything and holds back only writes. The scheduler raises a read or write request strobe and treats the access as issued only in a cycle where the matching enable is high. Completions are reported back with one strobe per class. A barrier finishes with a single-cycle done pulse, and its blocking is lifted on the following cycle.

Top module: `barrier_gate`

## Requirements
- R1: After reset both issue enables are high, bar_done is low, no barrier is pending and both outstanding counts are zero.
- R2: A read (write) issues when rd_req (wr_req) is high while rd_en (wr_en) is high. Each issue adds one to that class's outstanding count and each completion strobe removes one. An issue and a completion of the same class in the same cycle leave the count unchanged.
- R3: Type code 0, and any code other than 4, 16, 17, 18 or 19, waits for outstanding reads and writes and blocks both classes.
- R4: Type code 4 waits only for outstanding writes and blocks only writes. Reads keep issuing while it is pending, and a write request made while writes are blocked is not issued and is not counted.
- R5: Type code 16 waits for outstanding reads and writes and blocks both classes.
- R6: Type code 17 (acquire) waits only for outstanding reads and blocks both classes.
- R7: Type code 18 (release) waits for outstanding reads and writes and blocks only writes.
- R8: Type code 19 waits only for outstanding reads and blocks only reads.
- R9: A barrier request is accepted when bar_req is high and no barrier is pending. Blocking starts on the next cycle. bar_done is high for exactly one cycle, the first cycle in which the barrier is pending and every count it waits for is zero. Both enables are high again on the following cycle.
- R10: A barrier request made while a barrier is pending is ignored. It neither changes the pending barrier's type nor leaves a second barrier behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read issue request |
| wr_req | input | 1 | Write issue request |
| rd_done | input | 1 | One earlier read has completed |
| wr_done | input | 1 | One earlier write has completed |
| bar_req | input | 1 | Barrier request |
| bar_type | input | TYPE_W (5) | Barrier type code |
| rd_en | output | 1 | Reads may issue this cycle |
| wr_en | output | 1 | Writes may issue this cycle |
| bar_done | output | 1 | Pending barrier retires this cycle |

## Verification
Two pairs of events can fall in the same cycle. The first is a read issue and a read completion. The bench drives both strobes in one cycle with one read already outstanding, then raises a read-only barrier. That barrier must stay open until one more completion, so a count that moved in either direction shows up as bar_done arriving early or late. The second pair is a barrier request that arrives while another barrier is pending, with a different type code. It is judged by the enables after the first barrier retires: the read enable must be high, which a read-blocking second barrier would have prevented.

// File: rtl/barrier_gate.sv
module barrier_gate #(
  parameter int CNT_W  = 4,
  parameter int TYPE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              rd_done,
  input  logic              wr_done,
  input  logic              bar_req,
  input  logic [TYPE_W-1:0] bar_type,
  output logic              rd_en,
  output logic              wr_en,
  output logic              bar_done
);
  localparam logic [TYPE_W-1:0] T_WRITES  = TYPE_W'(4);
  localparam logic [TYPE_W-1:0] T_FULL    = TYPE_W'(16);
  localparam logic [TYPE_W-1:0] T_ACQUIRE = TYPE_W'(17);
  localparam logic [TYPE_W-1:0] T_RELEASE = TYPE_W'(18);
  localparam logic [TYPE_W-1:0] T_READS   = TYPE_W'(19);

  logic             pend, wt_rd, wt_wr, bk_rd, bk_wr;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic             n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr;
  logic             rd_fire, wr_fire, accept;

  always_comb begin
    {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1111;
    case (bar_type)
      T_WRITES:  {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b0101;
      T_FULL:    {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1111;
      T_ACQUIRE: {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1011;
      T_RELEASE: {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1101;
      T_READS:   {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1010;
      default:   {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr} = 4'b1111;
    endcase
  end

  assign rd_en    = !(pend && bk_rd);
  assign wr_en    = !(pend && bk_wr);
  assign rd_fire  = rd_req && rd_en;
  assign wr_fire  = wr_req && wr_en;
  assign accept   = bar_req && !pend;
  assign bar_done = pend && (!wt_rd || rd_cnt == '0) && (!wt_wr || wr_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      {wt_rd, wt_wr, bk_rd, bk_wr} <= 4'b0000;
    end else if (accept) begin
      pend <= 1'b1;
      {wt_rd, wt_wr, bk_rd, bk_wr} <= {n_wt_rd, n_wt_wr, n_bk_rd, n_bk_wr};
    end else if (bar_done) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else begin
      case ({rd_fire, rd_done})
        2'b10:   rd_cnt <= rd_cnt + 1'b1;
        2'b01:   rd_cnt <= rd_cnt - 1'b1;
        default: rd_cnt <= rd_cnt;
      endcase
      case ({wr_fire, wr_done})
        2'b10:   wr_cnt <= wr_cnt + 1'b1;
        2'b01:   wr_cnt <= wr_cnt - 1'b1;
        default: wr_cnt <= wr_cnt;
      endcase
    end
  end
endmodule

// File: rtl/barrier_gate_chk.sv
module barrier_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_done,
  input logic             bar_req,
  input logic             rd_en,
  input logic             wr_en,
  input logic             bar_done,
  input logic             pend,
  input logic             bk_rd,
  input logic             bk_wr,
  input logic [CNT_W-1:0] rd_cnt
);
  p_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_en && rd_done) |=> $stable(rd_cnt));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> (rd_en && wr_en));

  p_block_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_en) || $fell(wr_en)) |-> $past(bar_req));

  p_ignore_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && bar_req && !bar_done) |=> (pend && $stable(bk_rd) && $stable(bk_wr)));

  p_reads_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !bk_rd) |-> rd_en);
endmodule

bind barrier_gate barrier_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_done(rd_done),
  .bar_req(bar_req), .rd_en(rd_en), .wr_en(wr_en), .bar_done(bar_done),
  .pend(pend), .bk_rd(bk_rd), .bk_wr(bk_wr), .rd_cnt(rd_cnt)
);

// File: tb/barrier_gate_tb.sv
module barrier_gate_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, rd_done = 0, wr_done = 0, bar_req = 0;
  logic [4:0] bar_type = '0;
  logic rd_en, wr_en, bar_done;
  int runs = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  barrier_gate u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .rd_done(rd_done), .wr_done(wr_done), .bar_req(bar_req),
    .bar_type(bar_type), .rd_en(rd_en), .wr_en(wr_en), .bar_done(bar_done)
  );

  // {type, blocks reads, blocks writes, retires once reads drain}
  localparam logic [7:0] VEC [8] = '{
    {5'd0,  3'b110}, // R3
    {5'd4,  3'b010}, // R4
    {5'd16, 3'b110}, // R5
    {5'd17, 3'b111}, // R6
    {5'd18, 3'b010}, // R7
    {5'd19, 3'b101}, // R8
    {5'd7,  3'b110}, // R3 unknown code
    {5'd31, 3'b110}  // R3 unknown code
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 rd_en", rd_en, 1'b1);
    chk("R1 wr_en", wr_en, 1'b1);
    chk("R1 bar_done", bar_done, 1'b0);

    for (int v = 0; v < 8; v++) begin
      logic br, bw, dr;
      {br, bw, dr} = VEC[v][2:0];
      @(negedge clk); rd_req = 1; wr_req = 1;
      @(negedge clk); rd_req = 0; wr_req = 0; bar_req = 1; bar_type = VEC[v][7:3];
      @(negedge clk); bar_req = 0; #1;
      chk($sformatf("R3-R8 type %0d rd_en", VEC[v][7:3]), rd_en, !br);
      chk($sformatf("R3-R8 type %0d wr_en", VEC[v][7:3]), wr_en, !bw);
      chk("R9 not done early", bar_done, 1'b0);
      rd_done = 1;
      @(negedge clk); rd_done = 0; #1;
      chk($sformatf("R9 type %0d done after reads", VEC[v][7:3]), bar_done, dr);
      chk("R9 still blocked", rd_en, !br);
      wr_done = 1;
      if (dr) begin
        @(negedge clk); wr_done = 0; #1;
      end else begin
        @(negedge clk); wr_done = 0; #1;
        chk($sformatf("R9 type %0d done after writes", VEC[v][7:3]), bar_done, 1'b1);
        @(negedge clk); #1;
      end
      chk("R9 released rd_en", rd_en, 1'b1);
      chk("R9 released wr_en", wr_en, 1'b1);
      chk("R9 pulse ended", bar_done, 1'b0);
    end

    // R2: issue and completion of a read in the same cycle
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 1; rd_done = 1;
    @(negedge clk); rd_req = 0; rd_done = 0; bar_req = 1; bar_type = 5'd19;
    @(negedge clk); bar_req = 0; #1;
    chk("R2 one read still outstanding", bar_done, 1'b0);
    chk("R8 reads blocked", rd_en, 1'b0);
    rd_done = 1;
    @(negedge clk); rd_done = 0; #1;
    chk("R2 done after last read", bar_done, 1'b1);
    @(negedge clk); #1;
    chk("R9 reads released", rd_en, 1'b1);

    // R4: write barrier ignores reads; blocked write not counted
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0; bar_req = 1; bar_type = 5'd4;
    @(negedge clk); bar_req = 0; #1;
    chk("R4 done with read outstanding", bar_done, 1'b1);
    chk("R4 reads flow", rd_en, 1'b1);
    chk("R4 writes blocked", wr_en, 1'b0);
    wr_req = 1;
    @(negedge clk); wr_req = 0; #1;
    chk("R4 writes released", wr_en, 1'b1);
    bar_req = 1; bar_type = 5'd4;
    @(negedge clk); bar_req = 0; #1;
    chk("R4 blocked write not counted", bar_done, 1'b1);
    rd_done = 1;
    @(negedge clk); rd_done = 0;

    // R10: request while pending is ignored
    @(negedge clk); wr_req = 1;
    @(negedge clk); wr_req = 0; bar_req = 1; bar_type = 5'd0;
    @(negedge clk); bar_req = 1; bar_type = 5'd19; #1;
    chk("R10 first barrier blocks reads", rd_en, 1'b0);
    @(negedge clk); bar_req = 0; wr_done = 1;
    @(negedge clk); wr_done = 0; #1;
    chk("R10 first barrier retires", bar_done, 1'b1);
    @(negedge clk); #1;
    chk("R10 no second barrier rd_en", rd_en, 1'b1);
    chk("R10 no second barrier done", bar_done, 1'b0);

    // R7 with several writes
    repeat (3) begin @(negedge clk); wr_req = 1; end
    @(negedge clk); wr_req = 0; bar_req = 1; bar_type = 5'd18;
    @(negedge clk); bar_req = 0; #1;
    chk("R7 reads flow", rd_en, 1'b1);
    wr_done = 1;
    @(negedge clk);
    @(negedge clk); wr_done = 0; #1;
    chk("R2 one write left", bar_done, 1'b0);
    wr_done = 1;
    @(negedge clk); wr_done = 0; #1;
    chk("R7 done after writes", bar_done, 1'b1);
    @(negedge clk); #1;
    chk("R9 writes released", wr_en, 1'b1);

    report();
  end
endmodule